// File: doc/BRIEF.md
# DMA Stream Event Flag Bank

This block holds the event flags of an eight-stream DMA controller. Each stream raises one-cycle pulses for five kinds of event: transfer complete, half transfer, transfer error, direct-mode error and FIFO error. Every pulse sets a sticky flag. The flags are packed into two 32-bit status words, one for streams 0 to 3 and one for streams 4 to 7. Software reads them through a simple 32-bit register port.

Software acknowledges flags by writing ones to one of two write-only clear words. Each clear word mirrors the layout of its status word. The block also drives one level interrupt per stream. That line is the OR of the stream's flags, each masked by its own enable input. The DMA datapath, its enables and its configuration live elsewhere and reach this block only as pulses and enable levels.

Top module: `dma_flag_bank`

## Requirements
- R1: After reset every flag is zero, both status words read 0x00000000 and every interrupt output is low.
- R2: An event pulse on stream s sets its flag at the next rising edge. Streams 0 to 3 appear in the word at byte address 0x0 and streams 4 to 7 in the word at 0x4. The 6-bit field of stream s starts at bit ((s & 2) << 3) | ((s & 1) * 6), which is 0, 6, 16 or 22. Within the field, bit 0 is FIFO error, bit 2 direct-mode error, bit 3 transfer error, bit 4 half transfer and bit 5 transfer complete.
- R3: A write to address 0x8 (streams 0 to 3) or 0xC (streams 4 to 7) clears, from the next edge, each flag whose bit in the written data is 1. Bits written as 0 leave their flags unchanged, and a clear word never touches the other half.
- R4: When an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: Flags are sticky. They hold until cleared, whatever the state of the enable inputs.
- R6: Field bit 1, status bits 12 to 15 and status bits 28 to 31 always read zero. Reads of addresses 0x8 and 0xC return zero.
- R7: irq_o[s] is high exactly while at least one flag of stream s is set together with that flag's enable. A transfer-complete flag alone raises the line only when the transfer-complete enable of that stream is set.
- R8: Writes to the status addresses 0x0 and 0x4 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_fe_i | input | 8 | FIFO error pulse per stream |
| ev_dme_i | input | 8 | Direct-mode error pulse per stream |
| ev_te_i | input | 8 | Transfer error pulse per stream |
| ev_ht_i | input | 8 | Half transfer pulse per stream |
| ev_tc_i | input | 8 | Transfer complete pulse per stream |
| ie_fe_i | input | 8 | FIFO error interrupt enable per stream |
| ie_dme_i | input | 8 | Direct-mode error interrupt enable per stream |
| ie_te_i | input | 8 | Transfer error interrupt enable per stream |
| ie_ht_i | input | 8 | Half transfer interrupt enable per stream |
| ie_tc_i | input | 8 | Transfer complete interrupt enable per stream |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 8 | Interrupt line per stream |

## Verification
The assertions assume that event pulses and register writes are sampled on the rising edge only. Address bits 1:0 are taken as don't-care, and the write strobe is a single-cycle level with no read side effects. The stimulus changes every input on the falling edge and keeps pulses and write strobes to one cycle. Where it drives an event and a clear on the same flag, it does so deliberately, to check that the set wins. Reads are made half a cycle after the edge, once the packed words have settled.

// File: rtl/dma_flag_bank_pkg.sv
package dma_flag_bank_pkg;

    localparam int FIELD_W    = 6;
    localparam int WORD_W     = 32;
    localparam int PER_WORD   = 4;
    localparam int NUM_WORDS  = 2;

    // Field layout: bit order is decoded by software, so it is fixed.
    typedef struct packed {
        logic tc;   // bit 5
        logic ht;   // bit 4
        logic te;   // bit 3
        logic dme;  // bit 2
        logic rsv;  // bit 1, always zero
        logic fe;   // bit 0
    } flag_field_t;

    typedef enum logic [1:0] {
        SEL_STAT_LO = 2'd0,
        SEL_STAT_HI = 2'd1,
        SEL_CLR_LO  = 2'd2,
        SEL_CLR_HI  = 2'd3
    } word_sel_e;

    localparam flag_field_t FIELD_LIVE = '{tc: 1'b1, ht: 1'b1, te: 1'b1,
                                           dme: 1'b1, rsv: 1'b0, fe: 1'b1};

    function automatic int field_lsb(input int idx);
        return ((idx & 2) << 3) | ((idx & 1) * 6);
    endfunction

    function automatic int word_of(input int idx);
        return idx / PER_WORD;
    endfunction

endpackage

// File: rtl/dma_flag_stream.sv
module dma_flag_stream
    import dma_flag_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  flag_field_t set_i,
    input  flag_field_t clr_i,
    input  flag_field_t ie_i,
    output flag_field_t flags_o,
    output logic        irq_o
);

    flag_field_t flags_q;
    flag_field_t flags_d;

    always_comb begin
        flags_d = ((flags_q & ~clr_i) | set_i) & FIELD_LIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & ie_i & FIELD_LIVE);

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ($past(set_i) & FIELD_LIVE)) == ($past(set_i) & FIELD_LIVE))); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(clr_i) & ~$past(set_i)) == '0)); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i))); // R5

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> !irq_o); // R7

endmodule

// File: rtl/dma_flag_clrdec.sv
module dma_flag_clrdec
    import dma_flag_bank_pkg::*;
#(
    parameter int NUM_STREAMS = 8
) (
    input  logic                          wr_i,
    input  word_sel_e                     sel_i,
    input  logic [WORD_W-1:0]             wdata_i,
    output flag_field_t [NUM_STREAMS-1:0] clr_o
);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_dec
        localparam int        LSB   = field_lsb(s);
        localparam word_sel_e MYSEL = (word_of(s) == 0) ? SEL_CLR_LO : SEL_CLR_HI;
        always_comb begin
            clr_o[s] = '0;
            if (wr_i && (sel_i == MYSEL))
                clr_o[s] = flag_field_t'(wdata_i[LSB +: FIELD_W]) & FIELD_LIVE;
        end
    end

endmodule

// File: rtl/dma_flag_pack.sv
module dma_flag_pack
    import dma_flag_bank_pkg::*;
#(
    parameter int NUM_STREAMS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  flag_field_t [NUM_STREAMS-1:0] flags_i,
    input  word_sel_e                     sel_i,
    output logic [WORD_W-1:0]             rdata_o
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] stat_w;

    always_comb begin
        stat_w = '0;
        for (int s = 0; s < NUM_STREAMS; s++)
            stat_w[word_of(s)][field_lsb(s) +: FIELD_W] = flags_i[s];
    end

    always_comb begin
        unique case (sel_i)
            SEL_STAT_LO: rdata_o = stat_w[0];
            SEL_STAT_HI: rdata_o = stat_w[1];
            default:     rdata_o = '0;
        endcase
    end

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        sel_i[1] |-> (rdata_o == '0)); // R6

    AST_GAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rdata_o & 32'hF082_F082) == '0); // R6

endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
    import dma_flag_bank_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int ADDR_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] ev_fe_i,
    input  logic [NUM_STREAMS-1:0] ev_dme_i,
    input  logic [NUM_STREAMS-1:0] ev_te_i,
    input  logic [NUM_STREAMS-1:0] ev_ht_i,
    input  logic [NUM_STREAMS-1:0] ev_tc_i,
    input  logic [NUM_STREAMS-1:0] ie_fe_i,
    input  logic [NUM_STREAMS-1:0] ie_dme_i,
    input  logic [NUM_STREAMS-1:0] ie_te_i,
    input  logic [NUM_STREAMS-1:0] ie_ht_i,
    input  logic [NUM_STREAMS-1:0] ie_tc_i,
    input  logic                   reg_wr_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [WORD_W-1:0]      reg_wdata_i,
    output logic [WORD_W-1:0]      reg_rdata_o,
    output logic [NUM_STREAMS-1:0] irq_o
);

    word_sel_e                     sel;
    flag_field_t [NUM_STREAMS-1:0] clr;
    flag_field_t [NUM_STREAMS-1:0] flags;
    logic                          any_ev;

    assign sel    = word_sel_e'(reg_addr_i[3:2]);
    assign any_ev = |{ev_fe_i, ev_dme_i, ev_te_i, ev_ht_i, ev_tc_i};

    dma_flag_clrdec #(.NUM_STREAMS(NUM_STREAMS)) u_clrdec (
        .wr_i    (reg_wr_i),
        .sel_i   (sel),
        .wdata_i (reg_wdata_i),
        .clr_o   (clr)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        flag_field_t set_s;
        flag_field_t ie_s;
        assign set_s = '{tc: ev_tc_i[s], ht: ev_ht_i[s], te: ev_te_i[s],
                         dme: ev_dme_i[s], rsv: 1'b0, fe: ev_fe_i[s]};
        assign ie_s  = '{tc: ie_tc_i[s], ht: ie_ht_i[s], te: ie_te_i[s],
                         dme: ie_dme_i[s], rsv: 1'b0, fe: ie_fe_i[s]};
        dma_flag_stream u_stream (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_s),
            .clr_i   (clr[s]),
            .ie_i    (ie_s),
            .flags_o (flags[s]),
            .irq_o   (irq_o[s])
        );
    end

    dma_flag_pack #(.NUM_STREAMS(NUM_STREAMS)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .sel_i   (sel),
        .rdata_o (reg_rdata_o)
    );

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && !reg_addr_i[3] && !any_ev) |=> $stable(flags)); // R8

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && irq_o == '0)); // R1

endmodule

// File: tb/dma_flag_bank_test.sv
`timescale 1ns/1ps
module dma_flag_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0][7:0] evk = '0;
    logic [5:0][7:0] iek = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_flag_bank uut (
        .clk(clk), .rst(rst),
        .ev_fe_i(evk[0]), .ev_dme_i(evk[2]), .ev_te_i(evk[3]),
        .ev_ht_i(evk[4]), .ev_tc_i(evk[5]),
        .ie_fe_i(iek[0]), .ie_dme_i(iek[2]), .ie_te_i(iek[3]),
        .ie_ht_i(iek[4]), .ie_tc_i(iek[5]),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [2:0]  strm;
        logic [2:0]  kind;
        logic        hi;
        logic [31:0] word;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd5, 1'b0, 32'h0000_0020},
        '{3'd1, 3'd0, 1'b0, 32'h0000_0040},
        '{3'd2, 3'd3, 1'b0, 32'h0008_0000},
        '{3'd3, 3'd2, 1'b0, 32'h0100_0000},
        '{3'd3, 3'd3, 1'b0, 32'h0200_0000},
        '{3'd4, 3'd4, 1'b1, 32'h0000_0010},
        '{3'd5, 3'd5, 1'b1, 32'h0000_0800},
        '{3'd6, 3'd0, 1'b1, 32'h0001_0000},
        '{3'd7, 3'd5, 1'b1, 32'h0800_0000},
        '{3'd7, 3'd4, 1'b1, 32'h0400_0000}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int s, input int k);
        evk[k][s] = 1'b1;
        tick();
        evk = '0;
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: clean state after reset
        rd(4'h0, d); check("R1 low status", d, 32'h0);
        rd(4'h4, d); check("R1 high status", d, 32'h0);
        check("R1 irq", {24'h0, irq}, 32'h0);

        // R2/R3 table walk: placement, then clear
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i].strm, VEC[i].kind);
            rd(VEC[i].hi ? 4'h4 : 4'h0, d); check("R2 placement", d, VEC[i].word);
            rd(VEC[i].hi ? 4'h0 : 4'h4, d); check("R2 other half", d, 32'h0);
            wr(VEC[i].hi ? 4'hC : 4'h8, VEC[i].word);
            rd(VEC[i].hi ? 4'h4 : 4'h0, d); check("R3 cleared", d, 32'h0);
        end

        // R6: every event on every stream, reserved bits stay zero
        evk[0] = 8'hFF; evk[2] = 8'hFF; evk[3] = 8'hFF; evk[4] = 8'hFF; evk[5] = 8'hFF;
        tick();
        evk = '0;
        rd(4'h0, d); check("R6 low all set", d, 32'h0F7D_0F7D);
        rd(4'h4, d); check("R6 high all set", d, 32'h0F7D_0F7D);
        rd(4'h8, d); check("R6 clear low reads zero", d, 32'h0);
        rd(4'hC, d); check("R6 clear high reads zero", d, 32'h0);

        // R8: status writes ignored
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h4, 32'h0000_0000);
        rd(4'h0, d); check("R8 low unchanged", d, 32'h0F7D_0F7D);
        rd(4'h4, d); check("R8 high unchanged", d, 32'h0F7D_0F7D);

        // R3: clear high must not touch low half
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h4, d); check("R3 high cleared", d, 32'h0);
        rd(4'h0, d); check("R3 low untouched", d, 32'h0F7D_0F7D);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, d); check("R3 low cleared", d, 32'h0);

        // R3: zero bits in clear data have no effect
        evk[5][0] = 1'b1; evk[0][0] = 1'b1;
        tick();
        evk = '0;
        wr(4'h8, 32'h0000_0001);
        rd(4'h0, d); check("R3 partial clear", d, 32'h0000_0020);
        wr(4'h8, 32'h0000_0020);

        // R4: set wins over same-cycle clear
        evk[5][1] = 1'b1;
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h0000_0800;
        tick();
        evk = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(4'h0, d); check("R4 set beats clear", d, 32'h0000_0800);

        // R7/R5: gating and stickiness on stream 1 (tc set)
        check("R7 irq off without enable", {24'h0, irq}, 32'h0);
        iek[3][1] = 1'b1; #1;
        check("R7 other enable no irq", {24'h0, irq}, 32'h0);
        iek[5][1] = 1'b1; #1;
        check("R7 tc enable raises irq", {24'h0, irq}, 32'h0000_0002);
        iek = '0;
        tick(); tick();
        rd(4'h0, d); check("R5 flag sticky after disable", d, 32'h0000_0800);
        check("R7 irq dropped", {24'h0, irq}, 32'h0);

        // R7: error flag with its own enable on stream 6
        pulse(6, 3);
        iek[3][6] = 1'b1; #1;
        check("R7 te enable irq", {24'h0, irq}, 32'h0000_0040);
        wr(4'hC, 32'h0008_0000);
        check("R7 irq after clear", {24'h0, irq}, 32'h0);
        iek = '0;

        // R1: reset while flags set
        pulse(7, 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        rd(4'h0, d); check("R1 low after reset", d, 32'h0);
        rd(4'h4, d); check("R1 high after reset", d, 32'h0);

        done = 1'b1;
        report();
    end

endmodule